// File: doc/BRIEF.md
# Sample-and-Hold Acquisition Window Timer

This block times the acquisition phase that comes before each conversion. A one-cycle start request opens a window. During the window the `acquire` output is held high so the sample-and-hold input tracks the signal. When the window closes, a one-cycle `done` pulse tells the converter that it may begin.

The window length has two parts. The first is a fixed base that depends on the conversion kind: a full-resolution conversion uses a long base, and a short conversion or limit comparison uses a short base. The second part adds twice a 4-bit extension value taken from the instruction word. The extension lets slower or higher-impedance sources settle before the sample is taken. The mode and the extension are captured when the window opens. Changes to those inputs while the window is running have no effect.

Top module: `acq_window_timer`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `acquire` and `done` are low. With no start request, the block stays idle.
- R2: With `mode` = 0 (full-resolution conversion), an accepted start holds `acquire` high for exactly 9 + 2·`ext` consecutive cycles.
- R3: With `mode` = 1 (short conversion or limit comparison), an accepted start holds `acquire` high for exactly 2 + 2·`ext` consecutive cycles.
- R4: `ext` = 0 gives the minimum window: 9 cycles in mode 0 and 2 cycles in mode 1. `ext` = 15 gives the maximum window: 39 cycles in mode 0 and 32 cycles in mode 1.
- R5: `mode` and `ext` are sampled on the cycle that the start is accepted. Changing them later in the window does not change its length.
- R6: `done` is high for exactly one cycle, on the cycle right after the last `acquire` cycle. It is never high together with `acquire`.
- R7: A `start` that arrives while `acquire` is high is ignored. The running window keeps its length and no new window follows it.
- R8: A start is accepted whenever `acquire` is low, including the cycle on which `done` is high. `acquire` rises on the cycle after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to open an acquisition window |
| mode | input | 1 | 0 = full-resolution conversion, 1 = short conversion or limit comparison |
| ext | input | 4 | Programmed extension D; adds 2·D cycles to the window |
| acquire | output | 1 | High while the sample-and-hold acquires |
| done | output | 1 | One-cycle pulse after the window closes |

## Verification
A wrong count load or a wrong base selection appears only at the end of a window. The fall of `acquire` and the `done` pulse arrive early or late by a multiple of one or two cycles, so a faulty length is exposed at most 39 cycles after the start. A stuck busy state appears immediately: `acquire` fails to fall, or a later start is refused. A re-arm on a start during a busy window appears on the first cycle after `done`, as an unexpected `acquire`. The per-cycle model flags any of these faults on the exact cycle where it first shows.

// File: rtl/acq_win_pkg.sv
package acq_win_pkg;
  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SHORT = 1'b1
  } acq_mode_e;
endpackage

// File: rtl/acq_len_calc.sv
module acq_len_calc
  import acq_win_pkg::*;
#(
  parameter int EXT_W      = 4,
  parameter int BASE_FULL  = 9,
  parameter int BASE_SHORT = 2,
  parameter int LEN_W      = 6
) (
  input  acq_mode_e        mode,
  input  logic [EXT_W-1:0] ext,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] FULL_L  = LEN_W'(BASE_FULL);
  localparam logic [LEN_W-1:0] SHORT_L = LEN_W'(BASE_SHORT);

  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] extra;

  always_comb begin
    base  = (mode == MODE_FULL) ? FULL_L : SHORT_L;
    extra = LEN_W'({ext, 1'b0});
    len   = base + extra;
  end
endmodule

// File: rtl/acq_window_ctr.sv
module acq_window_ctr #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             acquire,
  output logic             done
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      acquire <= 1'b0;
      done    <= 1'b0;
      remain  <= '0;
    end else begin
      done <= 1'b0;
      if (acquire) begin
        if (remain == '0) begin
          acquire <= 1'b0;
          done    <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end else if (start) begin
        acquire <= 1'b1;
        remain  <= len - 1'b1;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!acquire && !done));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(acquire && done));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acquire && remain != '0) |=> acquire);
  // R8
  start_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!acquire && start) |=> acquire);
endmodule

// File: rtl/acq_window_timer.sv
module acq_window_timer
  import acq_win_pkg::*;
#(
  parameter int EXT_W      = 4,
  parameter int BASE_FULL  = 9,
  parameter int BASE_SHORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [EXT_W-1:0] ext,
  output logic             acquire,
  output logic             done
);
  localparam int MAX_BASE = (BASE_FULL > BASE_SHORT) ? BASE_FULL : BASE_SHORT;
  localparam int MAX_LEN  = MAX_BASE + 2 * ((1 << EXT_W) - 1);
  localparam int LEN_W    = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] win_len;

  acq_len_calc #(
    .EXT_W(EXT_W), .BASE_FULL(BASE_FULL), .BASE_SHORT(BASE_SHORT), .LEN_W(LEN_W)
  ) u_calc (
    .mode(acq_mode_e'(mode)),
    .ext (ext),
    .len (win_len)
  );

  acq_window_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .len    (win_len),
    .acquire(acquire),
    .done   (done)
  );

  // Observation logic for the checks below
  logic [LEN_W-1:0] held_len;
  logic [LEN_W-1:0] seen_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_len <= '0;
      seen_len <= '0;
    end else if (!acquire && start) begin
      held_len <= win_len;
      seen_len <= '0;
    end else if (acquire) begin
      seen_len <= seen_len + 1'b1;
    end
  end

  // R2 R3 R5
  len_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (seen_len == held_len));
  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (seen_len >= LEN_W'(BASE_SHORT) && seen_len <= LEN_W'(MAX_LEN)));
endmodule

// File: tb/acq_window_timer_test.sv
module acq_window_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] ext = 4'd0;
  logic       acquire, done;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string tag = "R1";

  // reference model state
  bit m_acq = 0;
  bit m_done = 0;
  int m_rem = 0;

  always #4 clk = ~clk;

  acq_window_timer uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ext(ext),
    .acquire(acquire), .done(done)
  );

  function automatic int win_len(input bit m, input int d);
    return (m ? 2 : 9) + 2 * d;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_acq = 0; m_done = 0; m_rem = 0;
    end else if (m_acq) begin
      m_rem--;
      m_acq  = (m_rem != 0);
      m_done = (m_rem == 0);
    end else begin
      m_done = 0;
      if (start) begin
        m_rem = win_len(mode, int'(ext));
        m_acq = 1;
      end
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(tag, "acquire", int'(acquire), int'(m_acq));
    check(tag, "done", int'(done), int'(m_done));
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  // Opens one window; scrambles mode/ext during it (R5); returns measured length
  task automatic window(input bit m, input int d, input string t, input bit scramble);
    int n = 0;
    tag = t;
    @(negedge clk);
    start = 1; mode = m; ext = 4'(d);
    @(negedge clk);
    start = 0;
    if (scramble) begin mode = ~m; ext = ~4'(d); end
    while (acquire && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(t, "window length", n, win_len(m, d));
    check(t, "done after window", int'(done), 1);
  endtask

  initial begin
    // R1: reset and idle
    repeat (3) @(negedge clk);
    check("R1", "acquire in reset", int'(acquire), 0);
    rst = 0;
    repeat (4) @(negedge clk);
    check("R1", "idle acquire", int'(acquire), 0);

    // R2 full mode, R3 short mode
    for (int d = 1; d < 15; d += 4) window(1'b0, d, "R2", 1'b0);
    for (int d = 1; d < 15; d += 4) window(1'b1, d, "R3", 1'b0);
    // R4 extremes
    window(1'b0, 0, "R4", 1'b0);
    window(1'b1, 0, "R4", 1'b0);
    window(1'b0, 15, "R4", 1'b0);
    window(1'b1, 15, "R4", 1'b0);
    // R5 inputs change during window
    window(1'b1, 3, "R5", 1'b1);
    window(1'b0, 6, "R5", 1'b1);

    // R7 start while busy
    tag = "R7";
    @(negedge clk);
    start = 1; mode = 1'b0; ext = 4'd2;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    start = 1; mode = 1'b1; ext = 4'd0;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    check("R7", "no rearm acquire", int'(acquire), 0);

    // R6 / R8 start on the done cycle
    tag = "R8";
    @(negedge clk);
    start = 1; mode = 1'b1; ext = 4'd1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    check("R6", "done alone", int'(acquire), 0);
    start = 1; mode = 1'b1; ext = 4'd0;
    @(negedge clk);
    start = 0;
    check("R8", "acquire after done-cycle start", int'(acquire), 1);
    check("R6", "done single cycle", int'(done), 0);
    repeat (5) @(negedge clk);

    // R1 mid-window reset
    tag = "R1";
    start = 1; mode = 1'b0; ext = 4'd5;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R1", "reset clears acquire", int'(acquire), 0);
    rst = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule